// File: doc/BRIEF.md
# Multiplexed Parallel Bus Host

This block is the host side of an external parallel bus for memories and peripherals. An internal requester gives an address, write data, a direction and a one-cycle start pulse. The block then runs one external bus transaction on the address pins, data pins, two chip-select pins, two address-latch strobes and two strobe pins. It reports busy while the transaction runs, then a one-cycle done pulse, with the captured read data.

Static configuration inputs choose how address and data share pins, from fully separate pins to three phases over one byte lane. They also choose whether each chip-select pin acts as a select or as an extra address bit, and the active level of every strobe and select. A last input chooses between a separate read/write strobe pair and a direction line paired with an enable strobe. Every phase lasts `PHASE_CYC` clock cycles.

Top module: `pbus_host`

## Requirements
- R1: While `cfg_en` is 0, a start pulse is ignored. `rsp_busy` stays 0, `bus_doe` stays 0, and no select, latch or strobe pin leaves its inactive level.
- R2: Multiplexing select `cfg_admux` sets the number of phases: 1 for 00, 2 for 01, 3 for 10, 2 for 11. Each phase lasts `PHASE_CYC` cycles. `rsp_busy` is 1 from the cycle after the accepted start to the last cycle of the final phase. `rsp_done` is 1 for exactly the next cycle, with `rsp_busy` 0.
- R3: Pin values during a transaction:
  - 00: `bus_addr` carries the full address; the data phase drives 16 data bits.
  - 01: `bus_addr[15:8]` carries the upper address byte and `bus_addr[7:0]` is 0. `bus_dout[7:0]` carries the low address byte in the address phase and the low data byte in the data phase.
  - 10: `bus_addr` is 0. `bus_dout[7:0]` carries the upper address byte in phase one, the lower address byte in phase two, and the low data byte in phase three.
  - 11: `bus_addr` is 0. `bus_dout` carries the full address, then the full data.
  - Unused `bus_dout` bits, and all pins when idle, are 0.
- R4: `bus_lat_lo` is asserted only in the middle cycle (index `PHASE_CYC/2`) of a lower-address phase. The lower-address phase is the only address phase of schemes 01 and 11, and the second phase of scheme 10. `bus_lat_hi` is asserted only in the middle cycle of the upper-address phase of scheme 10. Both use level `cfg_lat_pol` when asserted and its inverse otherwise.
- R5: `cfg_selfn` sets the role of each chip-select pin:
  - 10: both pins are selects.
  - 01: `bus_sel2` is a select and `bus_sel1` is address bit 14.
  - 00 or 11: `bus_sel1` is address bit 14 and `bus_sel2` is address bit 15.
  - A select is asserted for the whole busy window, at the level set by its own polarity bit (1 = active-high). An address-bit pin carries the bit while busy and 0 while idle, whatever its polarity bit says.
- R6: With `cfg_dir_mode`=0, `bus_strb_a` is a read strobe asserted through a read's data phase. `bus_strb_b` is a write strobe asserted through a write's data phase.
- R7: With `cfg_dir_mode`=1, `bus_strb_a` is a direction line. It is asserted for the whole busy window of a read and is inactive otherwise. `bus_strb_b` is an enable asserted through the data phase of either direction.
- R8: A strobe pin whose output-enable bit (`cfg_strb_a_oe`, `cfg_strb_b_oe`) is 0 is held at its inactive level, the inverse of its polarity bit.
- R9: A read captures `bus_din` in the last cycle of the data phase. `rsp_rdata` then equals all 16 bits for schemes 00 and 11, and `{8'h00, bus_din[7:0]}` for 01 and 10. `rsp_rdata` is unchanged by writes.
- R10: A start pulse while busy is ignored. The running transaction keeps its captured address, data and direction, and no second transaction follows it.
- R11: `bus_doe` is 1 throughout address phases and a write's data phase. It is 0 in a read's data phase and while idle.
- R12: After reset `rsp_busy`, `rsp_done` and `bus_doe` are 0, and `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Global enable; 0 blocks new transactions |
| cfg_admux | input | 2 | Address/data sharing scheme |
| cfg_selfn | input | 2 | Chip-select pin role |
| cfg_lat_pol | input | 1 | Latch strobe level when asserted |
| cfg_sel1_pol | input | 1 | Select 1 level when asserted |
| cfg_sel2_pol | input | 1 | Select 2 level when asserted |
| cfg_dir_mode | input | 1 | 1: direction plus enable; 0: separate read and write strobes |
| cfg_strb_a_oe | input | 1 | Drive enable of strobe pin A |
| cfg_strb_b_oe | input | 1 | Drive enable of strobe pin B |
| cfg_strb_a_pol | input | 1 | Strobe pin A level when asserted |
| cfg_strb_b_pol | input | 1 | Strobe pin B level when asserted |
| req_start | input | 1 | One-cycle transaction request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transaction address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Last read data |
| rsp_busy | output | 1 | Transaction in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_addr | output | 16 | Dedicated address pins |
| bus_dout | output | 16 | Data/address pins, output value |
| bus_doe | output | 1 | Data pin output enable |
| bus_din | input | 16 | Data pins, input value |
| bus_lat_lo | output | 1 | Lower address latch strobe |
| bus_lat_hi | output | 1 | Upper address latch strobe |
| bus_sel1 | output | 1 | Chip select 1 or address bit 14 |
| bus_sel2 | output | 1 | Chip select 2 or address bit 15 |
| bus_strb_a | output | 1 | Read strobe or direction line |
| bus_strb_b | output | 1 | Write strobe or enable strobe |

## Verification
The assertions rely on the configuration inputs other than the multiplexing select staying constant while a transaction runs, and on start being a pulse. Only the multiplexing select is captured at acceptance. The bench changes configuration only on the idle cycles between transactions. It sweeps every sharing scheme, every select-function code and both directions, and for each it derives polarity, output-enable and strobe-mode settings from the loop indices. During reads the bench drives a decoy value on `bus_din` everywhere except the final data cycle, so capture in any other cycle shows up as a wrong `rsp_rdata`.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_AHI  = 2'd1,
      PH_ALO  = 2'd2,
      PH_DATA = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      MX_SPLIT  = 2'b00,
      MX_LO8    = 2'b01,
      MX_FULL8  = 2'b10,
      MX_FULL16 = 2'b11
   } mux_e;

   typedef enum logic [1:0] {
      SF_ADDR = 2'b00,
      SF_SEL2 = 2'b01,
      SF_BOTH = 2'b10,
      SF_RSVD = 2'b11
   } selfn_e;

   function automatic phase_e first_phase(input mux_e m);
      unique case (m)
         MX_SPLIT: return PH_DATA;
         MX_FULL8: return PH_AHI;
         default:  return PH_ALO;
      endcase
   endfunction

   function automatic phase_e next_phase(input phase_e p);
      unique case (p)
         PH_AHI:  return PH_ALO;
         PH_ALO:  return PH_DATA;
         default: return PH_IDLE;
      endcase
   endfunction

   function automatic logic wide_data(input mux_e m);
      return (m == MX_SPLIT) || (m == MX_FULL16);
   endfunction

endpackage

// File: rtl/pbus_seq.sv
module pbus_seq import pbus_pkg::*; #(
   parameter int PHASE_CYC = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   en,
   input  logic   start,
   input  mux_e   mux,
   output logic   accept,
   output phase_e phase,
   output logic   mid,
   output logic   last_data,
   output logic   done
);

   localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYC - 1);
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(PHASE_CYC / 2);

   logic [CNT_W-1:0] cnt;
   logic             at_end;

   assign accept    = start && en && (phase == PH_IDLE);
   assign at_end    = (cnt == CNT_LAST);
   assign mid       = (cnt == CNT_MID);
   assign last_data = (phase == PH_DATA) && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= last_data;
         if (accept) begin
            phase <= first_phase(mux);
            cnt   <= '0;
         end else if (phase != PH_IDLE) begin
            if (at_end) begin
               cnt   <= '0;
               phase <= next_phase(phase);
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R2: completion is a single-cycle pulse
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2: done only appears once the bus is idle again
   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (phase == PH_IDLE));
   // R1: with the enable low an idle sequencer stays idle
   a_r1_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && !en) |=> (phase == PH_IDLE));
   // R2: a phase holds for its full cycle count
   a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && !at_end) |=> $stable(phase));

endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath import pbus_pkg::*; #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  mux_e              mux,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_write,
   input  phase_e            phase,
   input  logic              cap,
   input  logic [DATA_W-1:0] bus_din,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        top_abits,
   output logic              wr_q
);

   localparam int LANES = DATA_W / 8;

   logic [ADDR_W-1:0] a_q;
   logic [DATA_W-1:0] w_q;
   mux_e              mux_q;
   logic              wide_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= '0;
         w_q   <= '0;
         wr_q  <= 1'b0;
         mux_q <= MX_SPLIT;
      end else if (accept) begin
         a_q   <= req_addr;
         w_q   <= req_wdata;
         wr_q  <= req_write;
         mux_q <= mux;
      end
   end

   assign wide_q    = wide_data(mux_q);
   assign top_abits = a_q[ADDR_W-1 -: 2];

   always_comb begin
      bus_addr = '0;
      if (phase != PH_IDLE) begin
         unique case (mux_q)
            MX_SPLIT: bus_addr = a_q;
            MX_LO8:   bus_addr = {a_q[ADDR_W-1:8], 8'h00};
            default:  bus_addr = '0;
         endcase
      end
   end

   assign bus_doe = (phase == PH_AHI) || (phase == PH_ALO) ||
                    ((phase == PH_DATA) && wr_q);

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic [7:0] out_b;
      logic [7:0] cap_b;
      logic [7:0] rd_b;
      logic       lane_live;

      assign lane_live = wide_q || (b == 0);

      always_comb begin
         out_b = 8'h00;
         unique case (phase)
            PH_AHI:  if (b == 0) out_b = a_q[ADDR_W-1 -: 8];
            PH_ALO:  begin
               if (mux_q == MX_FULL16) out_b = a_q[b*8 +: 8];
               else if (b == 0)        out_b = a_q[7:0];
            end
            PH_DATA: if (wr_q && lane_live) out_b = w_q[b*8 +: 8];
            default: out_b = 8'h00;
         endcase
      end

      assign cap_b = lane_live ? bus_din[b*8 +: 8] : 8'h00;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          rd_b <= 8'h00;
         else if (cap && !wr_q) rd_b <= cap_b;
      end

      assign bus_dout[b*8 +: 8] = out_b;
      assign rdata[b*8 +: 8]    = rd_b;
   end

   // R11: data pins are released during a read's data phase
   a_r11_read_release: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && !wr_q) |-> !bus_doe);
   // R10: the captured request does not move while a transaction runs
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> ($stable(a_q) && $stable(w_q) && $stable(wr_q)));
   // R3: nothing is driven on the pins while idle
   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> (bus_dout == '0 && bus_addr == '0));

endmodule

// File: rtl/pbus_pins.sv
module pbus_pins import pbus_pkg::*; (
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e phase,
   input  logic   mid,
   input  logic   wr_q,
   input  logic [1:0] top_abits,
   input  selfn_e selfn,
   input  logic   lat_pol,
   input  logic [1:0] sel_pol,
   input  logic   dir_mode,
   input  logic [1:0] strb_oe,
   input  logic [1:0] strb_pol,
   output logic   lat_lo,
   output logic   lat_hi,
   output logic [1:0] sel,
   output logic [1:0] strb
);

   logic       busy;
   logic       in_data;
   logic       lo_act;
   logic       hi_act;
   logic [1:0] strb_act;

   assign busy    = (phase != PH_IDLE);
   assign in_data = (phase == PH_DATA);
   assign lo_act  = (phase == PH_ALO) && mid;
   assign hi_act  = (phase == PH_AHI) && mid;
   assign lat_lo  = lo_act ? lat_pol : ~lat_pol;
   assign lat_hi  = hi_act ? lat_pol : ~lat_pol;

   for (genvar i = 0; i < 2; i++) begin : g_sel
      logic as_sel;
      if (i == 0) begin : g_first
         assign as_sel = (selfn == SF_BOTH);
      end else begin : g_second
         assign as_sel = (selfn == SF_BOTH) || (selfn == SF_SEL2);
      end
      assign sel[i] = as_sel ? (busy ? sel_pol[i] : ~sel_pol[i])
                             : (busy & top_abits[i]);
   end

   // pin A: read strobe or direction line; pin B: write strobe or enable
   assign strb_act[0] = dir_mode ? (busy && !wr_q) : (in_data && !wr_q);
   assign strb_act[1] = dir_mode ? in_data : (in_data && wr_q);

   for (genvar s = 0; s < 2; s++) begin : g_strb
      assign strb[s] = (strb_oe[s] && strb_act[s]) ? strb_pol[s] : ~strb_pol[s];
   end

   // R4: the two latch strobes never fire together
   a_r4_one_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lo_act, hi_act}));
   // R6: separate strobes are mutually exclusive
   a_r6_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_mode |-> !(strb_act[0] && strb_act[1]));
   // R8: an undriven strobe pin rests at its inactive level
   a_r8_pin_a_off: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_oe[0] |-> (strb[0] == ~strb_pol[0]));
   a_r8_pin_b_off: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_oe[1] |-> (strb[1] == ~strb_pol[1]));

endmodule

// File: rtl/pbus_host.sv
module pbus_host import pbus_pkg::*; #(
   parameter int PHASE_CYC = 2,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [1:0]        cfg_admux,
   input  logic [1:0]        cfg_selfn,
   input  logic              cfg_lat_pol,
   input  logic              cfg_sel1_pol,
   input  logic              cfg_sel2_pol,
   input  logic              cfg_dir_mode,
   input  logic              cfg_strb_a_oe,
   input  logic              cfg_strb_b_oe,
   input  logic              cfg_strb_a_pol,
   input  logic              cfg_strb_b_pol,
   input  logic              req_start,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_busy,
   output logic              rsp_done,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic [DATA_W-1:0] bus_din,
   output logic              bus_lat_lo,
   output logic              bus_lat_hi,
   output logic              bus_sel1,
   output logic              bus_sel2,
   output logic              bus_strb_a,
   output logic              bus_strb_b
);

   if (PHASE_CYC < 1) begin : g_bad_phase
      $error("pbus_host: PHASE_CYC must be at least 1");
   end
   if (ADDR_W != 16 || DATA_W != 16) begin : g_bad_width
      $error("pbus_host: sharing schemes are defined for a 16-bit address and data");
   end

   mux_e       mux;
   phase_e     phase;
   logic       accept;
   logic       mid;
   logic       last_data;
   logic       wr_q;
   logic [1:0] top_abits;
   logic [1:0] sel;
   logic [1:0] strb;

   assign mux = mux_e'(cfg_admux);

   pbus_seq #(.PHASE_CYC(PHASE_CYC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cfg_en),
      .start     (req_start),
      .mux       (mux),
      .accept    (accept),
      .phase     (phase),
      .mid       (mid),
      .last_data (last_data),
      .done      (rsp_done)
   );

   pbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .mux       (mux),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_write (req_write),
      .phase     (phase),
      .cap       (last_data),
      .bus_din   (bus_din),
      .bus_addr  (bus_addr),
      .bus_dout  (bus_dout),
      .bus_doe   (bus_doe),
      .rdata     (rsp_rdata),
      .top_abits (top_abits),
      .wr_q      (wr_q)
   );

   pbus_pins u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase),
      .mid       (mid),
      .wr_q      (wr_q),
      .top_abits (top_abits),
      .selfn     (selfn_e'(cfg_selfn)),
      .lat_pol   (cfg_lat_pol),
      .sel_pol   ({cfg_sel2_pol, cfg_sel1_pol}),
      .dir_mode  (cfg_dir_mode),
      .strb_oe   ({cfg_strb_b_oe, cfg_strb_a_oe}),
      .strb_pol  ({cfg_strb_b_pol, cfg_strb_a_pol}),
      .lat_lo    (bus_lat_lo),
      .lat_hi    (bus_lat_hi),
      .sel       (sel),
      .strb      (strb)
   );

   assign bus_sel1   = sel[0];
   assign bus_sel2   = sel[1];
   assign bus_strb_a = strb[0];
   assign bus_strb_b = strb[1];
   assign rsp_busy   = (phase != PH_IDLE);

   // R10: a start during a transaction does not restart it
   a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_busy && req_start && !last_data) |=> rsp_busy);

endmodule

// File: tb/pbus_host_test.sv
`timescale 1ns/1ps
module pbus_host_test;

   localparam int P = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_en = 1'b0;
   logic [1:0]  cfg_admux = 2'b00;
   logic [1:0]  cfg_selfn = 2'b00;
   logic        cfg_lat_pol = 1'b0, cfg_sel1_pol = 1'b0, cfg_sel2_pol = 1'b0;
   logic        cfg_dir_mode = 1'b0;
   logic        cfg_strb_a_oe = 1'b0, cfg_strb_b_oe = 1'b0;
   logic        cfg_strb_a_pol = 1'b0, cfg_strb_b_pol = 1'b0;
   logic        req_start = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0, bus_din = '0;
   logic [15:0] rsp_rdata, bus_addr, bus_dout;
   logic        rsp_busy, rsp_done, bus_doe;
   logic        bus_lat_lo, bus_lat_hi, bus_sel1, bus_sel2, bus_strb_a, bus_strb_b;

   int checks = 0;
   int errors = 0;
   logic [15:0] last_rd = 16'h0000;

   always #5 clk = ~clk;

   pbus_host #(.PHASE_CYC(P)) uut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // kind: 0 upper address phase, 1 lower address phase, 2 data phase
   task automatic expect_pins(input bit bsy, input int kind, input int c,
                              input logic [15:0] a, input logic [15:0] w,
                              input bit wr, input string ctx);
      logic [15:0] ea, ed;
      bit eoe, lo_act, hi_act, s1, s2, ra, rb;
      bit sel1_cs, sel2_cs;
      ea = 16'h0;
      ed = 16'h0;
      if (bsy) begin
         if (cfg_admux == 2'b00) ea = a;
         else if (cfg_admux == 2'b01) ea = {a[15:8], 8'h00};
         if (kind == 0) ed = {8'h00, a[15:8]};
         else if (kind == 1) ed = (cfg_admux == 2'b11) ? a : {8'h00, a[7:0]};
         else if (wr) ed = (cfg_admux == 2'b00 || cfg_admux == 2'b11) ? w : {8'h00, w[7:0]};
      end
      eoe    = bsy && (kind != 2 || wr);
      lo_act = bsy && kind == 1 && c == P/2;
      hi_act = bsy && kind == 0 && c == P/2;
      sel1_cs = (cfg_selfn == 2'b10);
      sel2_cs = (cfg_selfn == 2'b10) || (cfg_selfn == 2'b01);
      s1 = sel1_cs ? (bsy ? cfg_sel1_pol : !cfg_sel1_pol) : (bsy && a[14]);
      s2 = sel2_cs ? (bsy ? cfg_sel2_pol : !cfg_sel2_pol) : (bsy && a[15]);
      ra = cfg_dir_mode ? (bsy && !wr) : (bsy && kind == 2 && !wr);
      rb = cfg_dir_mode ? (bsy && kind == 2) : (bsy && kind == 2 && wr);
      ra = (cfg_strb_a_oe && ra) ? cfg_strb_a_pol : !cfg_strb_a_pol;
      rb = (cfg_strb_b_oe && rb) ? cfg_strb_b_pol : !cfg_strb_b_pol;
      chk({"R3 address pins ", ctx}, bus_addr, ea);
      chk({"R3 data pins ", ctx}, bus_dout, ed);
      chk({"R11 data enable ", ctx}, bus_doe, eoe);
      chk({"R4 lower latch ", ctx}, bus_lat_lo, lo_act ? cfg_lat_pol : !cfg_lat_pol);
      chk({"R4 upper latch ", ctx}, bus_lat_hi, hi_act ? cfg_lat_pol : !cfg_lat_pol);
      chk({"R5 select pins ", ctx}, {bus_sel2, bus_sel1}, {s2, s1});
      if (!cfg_strb_a_oe || !cfg_strb_b_oe)
         chk({"R8 strobe pins ", ctx}, {bus_strb_b, bus_strb_a}, {rb, ra});
      else if (cfg_dir_mode)
         chk({"R7 strobe pins ", ctx}, {bus_strb_b, bus_strb_a}, {rb, ra});
      else
         chk({"R6 strobe pins ", ctx}, {bus_strb_b, bus_strb_a}, {rb, ra});
   endtask

   task automatic xact(input logic [15:0] a, input logic [15:0] w, input bit wr,
                       input logic [15:0] dv, input bit poke);
      int nph, n;
      logic [15:0] exp_rd;
      nph = (cfg_admux == 2'b00) ? 1 : (cfg_admux == 2'b10) ? 3 : 2;
      n = nph * P;
      @(negedge clk);
      req_addr = a; req_wdata = w; req_write = wr; req_start = 1'b1; bus_din = ~dv;
      @(negedge clk);
      req_start = 1'b0;
      for (int k = 0; k < n; k++) begin
         int ph, kind;
         if (k > 0) @(negedge clk);
         ph = k / P;
         kind = (ph == nph - 1) ? 2 : (nph == 3 && ph == 0) ? 0 : 1;
         chk("R2 busy during phases", rsp_busy, 1'b1);
         chk("R2 no done during phases", rsp_done, 1'b0);
         expect_pins(1'b1, kind, k % P, a, w, wr, "in transaction");
         bus_din = (k == n - 1) ? dv : ~dv;
         if (poke) begin
            // R10: a second request while busy must be dropped
            req_start = (k == 0);
            req_addr = ~a; req_wdata = ~w; req_write = !wr;
         end
      end
      @(negedge clk);
      req_start = 1'b0;
      bus_din = 16'h5AA5;
      chk("R2 done pulse", rsp_done, 1'b1);
      chk("R2 busy cleared at done", rsp_busy, 1'b0);
      if (!wr) begin
         exp_rd = (cfg_admux == 2'b00 || cfg_admux == 2'b11) ? dv : {8'h00, dv[7:0]};
         chk("R9 read data", rsp_rdata, exp_rd);
         last_rd = exp_rd;
      end else begin
         chk("R9 read data kept over write", rsp_rdata, last_rd);
      end
      expect_pins(1'b0, 0, 0, a, w, wr, "at done");
      @(negedge clk);
      chk("R2 done lasts one cycle", rsp_done, 1'b0);
      chk("R10 no second transaction", rsp_busy, 1'b0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 busy after reset", rsp_busy, 1'b0);
      chk("R12 done after reset", rsp_done, 1'b0);
      chk("R12 data enable after reset", bus_doe, 1'b0);
      chk("R12 read data after reset", rsp_rdata, 16'h0000);

      // R1: disabled block ignores start
      cfg_selfn = 2'b10; cfg_strb_a_oe = 1'b1; cfg_strb_b_oe = 1'b1;
      req_addr = 16'hC3C3; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      for (int k = 0; k < 4; k++) begin
         chk("R1 busy stays low when disabled", rsp_busy, 1'b0);
         chk("R1 data enable stays low when disabled", bus_doe, 1'b0);
         expect_pins(1'b0, 0, 0, 16'hC3C3, 16'h0, 1'b0, "R1 disabled");
         @(negedge clk);
      end
      cfg_en = 1'b1;

      for (int m = 0; m < 4; m++) begin
         for (int f = 0; f < 4; f++) begin
            for (int wr = 0; wr < 2; wr++) begin
               for (int pat = 0; pat < 8; pat++) begin
                  logic [7:0] h;
                  logic [15:0] a, w, dv;
                  h = 8'((pat * 37) + (m * 11) + (f * 5) + (wr * 3));
                  cfg_admux = 2'(m);
                  cfg_selfn = 2'(f);
                  {cfg_lat_pol, cfg_sel1_pol, cfg_sel2_pol, cfg_dir_mode} = h[3:0];
                  cfg_strb_a_pol = h[4];
                  cfg_strb_b_pol = h[5];
                  cfg_strb_a_oe = h[6] | pat[0];
                  cfg_strb_b_oe = h[7] | pat[1];
                  a  = (16'h1357 * 16'(pat + 1)) ^ {2'(m), 2'(f), 12'h5A3};
                  w  = 16'hB00F ^ (16'h0111 * 16'(pat + m));
                  dv = 16'h8E71 ^ (16'h0203 * 16'(pat + f + wr));
                  xact(a, w, wr[0], dv, pat == 3);
               end
            end
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule